// File: doc/BRIEF.md
# Multi-Octave Wavelet Decomposition Engine

This block computes a one-dimensional discrete wavelet transform over several octaves with a single pair of filters: a lowpass and a highpass dot product that are evaluated together in one cycle. Every octave shares that pair. A scheduler picks one octave per cycle. The first octave runs whenever two fresh input samples are waiting. Each higher octave runs in an otherwise idle cycle once two fresh lowpass results from the octave below have been stored for it. The engine keeps one history line of filter length per octave and no other storage.

Samples arrive on a valid/ready stream. Each computation produces one output beat that carries the lowpass and highpass results together with the octave index that produced them. The highpass result passes through a soft-threshold stage whose threshold is set at run time. A coefficient select input switches the filter pair to the time-reversed coefficient set used for synthesis, and the datapath is otherwise unchanged. The lowpass filter taps come from a parameter, and the highpass filter and the synthesis set are derived from those taps.

Top module: `dwt_pyramid`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1. All history lines start at zero.
- R2: A sample is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. Every second accepted sample triggers one octave-0 computation. That computation gives lo = Σ c_lo[i]·x[n−i] and hi = Σ c_hi[i]·x[n−i] over i = 0..TAPS−1, where x[n] is the newest sample and x[n−i] is taken as zero before reset release.
- R3: The input of octave j (j ≥ 1) is the sequence of octave j−1 lowpass results. Those results are taken after rounding and before any thresholding. Octave j computes once for every two new values it receives, using the same formula as octave 0.
- R4: Each sum is kept at full precision. The stage adds 2^(W−2), shifts arithmetically right by W−1 (Q1.15 coefficients for W=16), and saturates to [−2^(W−1), 2^(W−1)−1].
- R5: At most one octave computes per cycle, and the lowest-numbered ready octave wins. Octave j is held back while octave j+1 already has two values waiting. `in_ready` is 0 only when octave 0 has two samples waiting and does not compute in that cycle. No output is produced for an octave without two new inputs.
- R6: The result of a computation appears one cycle later, with `out_valid` high and `out_oct` set to the octave index (0 is the finest octave, OCT−1 the coarsest).
- R7: The lowpass taps are c_lo[i] = LP_FWD[i] and the highpass taps are c_hi[i] = (−1)^i · LP_FWD[TAPS−1−i]. When `coef_sel` is 1, both filters use their taps in reverse order, c'[i] = c[TAPS−1−i].
- R8: `out_hi` is soft-thresholded. With h the rounded highpass value and T = `thr`, the output is 0 if |h| ≤ T and sign(h)·(|h|−T) otherwise. `out_lo` is never thresholded.
- R9: No computation is lost under back-pressure. Within one octave, outputs leave in the order of their inputs, and when the input stops every completed pair has been emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Engine can take a sample |
| in_data | input | W | Input sample, two's complement |
| coef_sel | input | 1 | 0: analysis taps, 1: time-reversed synthesis taps |
| thr | input | W-1 | Soft-threshold level for the highpass result |
| out_valid | output | 1 | Output beat present |
| out_oct | output | $clog2(OCT) | Octave that produced the beat |
| out_lo | output | W | Lowpass result |
| out_hi | output | W | Thresholded highpass result |

## Verification
A corrupted history word affects the next TAPS/2 results of its own octave, which show up at the ports one cycle after each computation. Through the lowpass feed it then reaches every coarser octave, so a single bad word can appear in several octave tags. A wrong pending count in the scheduler shows up in one of three ways: as a beat whose octave tag has no expected pair, as a result computed from a shifted window, or as a pair that never leaves and is found missing once the stream drains. A threshold or sign fault is seen on `out_hi` alone, in the same cycle as the matching `out_lo`.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  typedef enum logic {
    CSET_ANALYSIS  = 1'b0,
    CSET_SYNTHESIS = 1'b1
  } cset_e;
endpackage

// File: rtl/dwt_sched.sv
module dwt_sched #(
  parameter int OCT = 5,
  localparam int OW = $clog2(OCT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          accept,
  output logic          go,
  output logic [OW-1:0] sel
);
  logic [1:0]     pend_q [OCT];
  logic [1:0]     pend_d [OCT];
  logic [OCT-1:0] elig;

  for (genvar j = 0; j < OCT; j++) begin : g_elig
    if (j == OCT - 1) begin : g_top
      assign elig[j] = (pend_q[j] == 2'd2);
    end else begin : g_mid
      assign elig[j] = (pend_q[j] == 2'd2) && (pend_q[j+1] != 2'd2);
    end
  end

  always_comb begin
    go  = 1'b0;
    sel = '0;
    for (int j = OCT - 1; j >= 0; j--) begin
      if (elig[j]) begin
        go  = 1'b1;
        sel = OW'(j);
      end
    end
  end

  assign in_ready = (pend_q[0] != 2'd2) || (go && (sel == '0));
  assign accept   = in_valid && in_ready;

  always_comb begin
    logic [1:0] base;
    logic       inc;
    for (int j = 0; j < OCT; j++) begin
      base = (go && (sel == OW'(j))) ? 2'd0 : pend_q[j];
      if (j == 0) inc = accept;
      else        inc = go && (sel == OW'(j - 1));
      pend_d[j] = base + {1'b0, inc};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < OCT; j++) pend_q[j] <= 2'd0;
    end else begin
      for (int j = 0; j < OCT; j++) pend_q[j] <= pend_d[j];
    end
  end

  // R5: a full octave-0 line may take a sample only when it computes now
  a_r5_ready_needs_compute: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] == 2'd2 && in_ready) |-> (go && sel == '0));

  // R5: octave 0 wins when it is ready and not held by octave 1
  a_r5_low_first: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] == 2'd2 && pend_q[1] != 2'd2) |-> (go && sel == '0));

  for (genvar j = 0; j < OCT; j++) begin : g_chk
    // R9: a waiting pair survives until its octave is computed
    a_r9_pair_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[j] == 2'd2 && !(go && sel == OW'(j))) |=> (pend_q[j] == 2'd2));
  end
endmodule

// File: rtl/dwt_store.sv
module dwt_store #(
  parameter int W    = 16,
  parameter int TAPS = 20,
  parameter int OCT  = 5,
  localparam int OW  = $clog2(OCT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic signed [W-1:0]  in_data,
  input  logic                 go,
  input  logic [OW-1:0]        sel,
  input  logic signed [W-1:0]  fb_data,
  output logic signed [W-1:0]  rd_line [TAPS]
);
  logic signed [W-1:0] line_q [OCT][TAPS];
  logic signed [W-1:0] line_d [OCT][TAPS];
  logic signed [W-1:0] head   [OCT];
  logic [OCT-1:0]      shift_en;

  always_comb begin
    shift_en[0] = accept;
    head[0]     = in_data;
    for (int j = 1; j < OCT; j++) begin
      shift_en[j] = go && (sel == OW'(j - 1));
      head[j]     = fb_data;
    end
  end

  always_comb begin
    for (int j = 0; j < OCT; j++) begin
      line_d[j][0] = shift_en[j] ? head[j] : line_q[j][0];
      for (int i = 1; i < TAPS; i++) begin
        line_d[j][i] = shift_en[j] ? line_q[j][i-1] : line_q[j][i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < OCT; j++)
        for (int i = 0; i < TAPS; i++) line_q[j][i] <= '0;
    end else begin
      for (int j = 0; j < OCT; j++)
        for (int i = 0; i < TAPS; i++) line_q[j][i] <= line_d[j][i];
    end
  end

  always_comb begin
    for (int i = 0; i < TAPS; i++) rd_line[i] = line_q[sel][i];
  end
endmodule

// File: rtl/dwt_fpair.sv
module dwt_fpair
  import dwt_pkg::*;
#(
  parameter int W    = 16,
  parameter int TAPS = 20,
  parameter logic signed [W-1:0] LP_FWD [TAPS] = '{default: '0},
  localparam int FRAC = W - 1,
  localparam int ACCW = 2 * W + $clog2(TAPS)
) (
  input  logic signed [W-1:0] x [TAPS],
  input  cset_e               cset,
  output logic signed [W-1:0] lo,
  output logic signed [W-1:0] hi
);
  localparam logic signed [ACCW-1:0] HALF =
    {{(ACCW - FRAC){1'b0}}, 1'b1, {(FRAC - 1){1'b0}}};
  localparam logic signed [ACCW-1:0] MAXV = ACCW'(2 ** (W - 1) - 1);
  localparam logic signed [ACCW-1:0] MINV = -MAXV - ACCW'(1);

  logic signed [W-1:0]    c_lo [TAPS];
  logic signed [W-1:0]    c_hi [TAPS];
  logic signed [ACCW-1:0] acc_lo, acc_hi;

  for (genvar i = 0; i < TAPS; i++) begin : g_coef
    localparam logic signed [W-1:0] LPA = LP_FWD[i];
    localparam logic signed [W-1:0] HPA =
      ((i % 2) == 1) ? -LP_FWD[TAPS-1-i] : LP_FWD[TAPS-1-i];
    localparam logic signed [W-1:0] LPS = LP_FWD[TAPS-1-i];
    localparam logic signed [W-1:0] HPS =
      (((TAPS - 1 - i) % 2) == 1) ? -LP_FWD[i] : LP_FWD[i];
    assign c_lo[i] = (cset == CSET_SYNTHESIS) ? LPS : LPA;
    assign c_hi[i] = (cset == CSET_SYNTHESIS) ? HPS : HPA;
  end

  always_comb begin
    acc_lo = '0;
    acc_hi = '0;
    for (int i = 0; i < TAPS; i++) begin
      acc_lo = acc_lo + ACCW'(x[i]) * ACCW'(c_lo[i]);
      acc_hi = acc_hi + ACCW'(x[i]) * ACCW'(c_hi[i]);
    end
  end

  function automatic logic signed [W-1:0] rnd_sat(input logic signed [ACCW-1:0] a);
    logic signed [ACCW-1:0] t;
    t = (a + HALF) >>> FRAC;
    if (t > MAXV)      return MAXV[W-1:0];
    else if (t < MINV) return MINV[W-1:0];
    else               return t[W-1:0];
  endfunction

  assign lo = rnd_sat(acc_lo);
  assign hi = rnd_sat(acc_hi);
endmodule

// File: rtl/dwt_shrink.sv
module dwt_shrink #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] x,
  input  logic [W-2:0]        thr,
  output logic signed [W-1:0] y
);
  logic [W-1:0] mag;
  logic [W-1:0] red;

  always_comb begin
    mag = x[W-1] ? W'(-x) : W'(x);
    red = mag - {1'b0, thr};
    if (mag <= {1'b0, thr}) y = '0;
    else if (x[W-1])        y = $signed(-red);
    else                    y = $signed(red);
  end
endmodule

// File: rtl/dwt_pyramid.sv
module dwt_pyramid
  import dwt_pkg::*;
#(
  parameter int W    = 16,
  parameter int TAPS = 20,
  parameter int OCT  = 5,
  parameter logic signed [W-1:0] LP_FWD [TAPS] = '{
    -16'sd2368,  16'sd0,     16'sd2368, -16'sd1472,  16'sd896,
    -16'sd2944, -16'sd576,   16'sd1792, -16'sd2048,  16'sd320,
     16'sd2688, -16'sd1152,  16'sd1216, -16'sd2624, -16'sd256,
     16'sd2112, -16'sd1728,  16'sd640,   16'sd3008, -16'sd832},
  localparam int OW = $clog2(OCT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_data,
  input  logic                coef_sel,
  input  logic [W-2:0]        thr,
  output logic                out_valid,
  output logic [OW-1:0]       out_oct,
  output logic signed [W-1:0] out_lo,
  output logic signed [W-1:0] out_hi
);
  logic                accept, go;
  logic [OW-1:0]       sel;
  logic signed [W-1:0] win [TAPS];
  logic signed [W-1:0] lo_raw, hi_raw, hi_shr;
  cset_e               cset;

  assign cset = cset_e'(coef_sel);

  dwt_sched #(.OCT(OCT)) u_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept), .go(go), .sel(sel));

  dwt_store #(.W(W), .TAPS(TAPS), .OCT(OCT)) u_store (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_data(in_data),
    .go(go), .sel(sel), .fb_data(lo_raw), .rd_line(win));

  dwt_fpair #(.W(W), .TAPS(TAPS), .LP_FWD(LP_FWD)) u_fpair (
    .x(win), .cset(cset), .lo(lo_raw), .hi(hi_raw));

  dwt_shrink #(.W(W)) u_shrink (.x(hi_raw), .thr(thr), .y(hi_shr));

  logic                v_q, v_d;
  logic [OW-1:0]       oct_q, oct_d;
  logic signed [W-1:0] lo_q, lo_d, hi_q, hi_d;

  always_comb begin
    v_d   = go;
    oct_d = go ? sel    : oct_q;
    lo_d  = go ? lo_raw : lo_q;
    hi_d  = go ? hi_shr : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      oct_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      v_q   <= v_d;
      oct_q <= oct_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
    end
  end

  assign out_valid = v_q;
  assign out_oct   = oct_q;
  assign out_lo    = lo_q;
  assign out_hi    = hi_q;

  // R6: tag always names an existing octave
  a_r6_oct_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_oct < OW'(OCT)));

  // R8: values inside the dead zone leave as zero
  a_r8_dead_zone: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (hi_raw <= $signed({1'b0, thr})) && (hi_raw >= -$signed({1'b0, thr})))
    |=> (out_hi == '0));

  // R8: shrinking keeps the sign and never grows a positive value
  a_r8_positive_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (go && hi_raw > 0) |=> (out_hi >= 0 && out_hi <= $past(hi_raw)));
endmodule

// File: tb/tb_dwt_pyramid.sv
module tb_dwt_pyramid;
  localparam int K = 20;
  localparam int J = 5;
  localparam int W = 16;
  localparam logic signed [W-1:0] LPB [K] = '{
    -16'sd2368,  16'sd0,     16'sd2368, -16'sd1472,  16'sd896,
    -16'sd2944, -16'sd576,   16'sd1792, -16'sd2048,  16'sd320,
     16'sd2688, -16'sd1152,  16'sd1216, -16'sd2624, -16'sd256,
     16'sd2112, -16'sd1728,  16'sd640,   16'sd3008, -16'sd832};

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic              rst_n, in_valid, in_ready, coef_sel, out_valid;
  logic signed [15:0] in_data, out_lo, out_hi;
  logic [14:0]       thr;
  logic [2:0]        out_oct;

  dwt_pyramid #(.W(W), .TAPS(K), .OCT(J), .LP_FWD(LPB)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .coef_sel(coef_sel), .thr(thr),
    .out_valid(out_valid), .out_oct(out_oct), .out_lo(out_lo), .out_hi(out_hi));

  typedef struct { int lo; int hi; } pair_t;
  pair_t expq [J][$];
  int hist [J][K];
  int cnt  [J];
  int n_chk = 0, n_bad = 0;
  int cs_b = 0, thr_b = 0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R7: tap rule from the requirement
  function automatic int coef(input int band, input int inv, input int i);
    int k;
    k = inv ? K - 1 - i : i;
    if (band == 0) return int'(LPB[k]);
    return ((k % 2) == 1) ? -int'(LPB[K-1-k]) : int'(LPB[K-1-k]);
  endfunction

  // R4: round half up, shift, saturate
  function automatic int rnd_sat(input longint a);
    longint t;
    t = (a + 64'sd16384) >>> 15;
    if (t > 32767)  return 32767;
    if (t < -32768) return -32768;
    return int'(t);
  endfunction

  // R8: soft threshold
  function automatic int shrink(input int x, input int t);
    int m;
    m = (x < 0) ? -x : x;
    if (m <= t) return 0;
    return (x < 0) ? -(m - t) : (m - t);
  endfunction

  task automatic model_in(input int v);
    int val;
    longint al, ah;
    int lo;
    val = v;
    for (int j = 0; j < J; j++) begin
      for (int i = K - 1; i > 0; i--) hist[j][i] = hist[j][i-1];
      hist[j][0] = val;
      cnt[j]++;
      if ((cnt[j] % 2) != 0) break;
      al = 0; ah = 0;
      for (int i = 0; i < K; i++) begin
        al += longint'(hist[j][i]) * longint'(coef(0, cs_b, i));
        ah += longint'(hist[j][i]) * longint'(coef(1, cs_b, i));
      end
      lo = rnd_sat(al);
      expq[j].push_back('{lo: lo, hi: shrink(rnd_sat(ah), thr_b)});
      val = lo;
    end
  endtask

  function automatic string tag_of(input int o, input int v, input bit is_hi);
    if (is_hi && thr_b != 0)       return $sformatf("R8 hi oct%0d", o);
    if (v == 32767 || v == -32768) return $sformatf("R4 %s oct%0d", is_hi ? "hi" : "lo", o);
    if (cs_b != 0)                 return $sformatf("R7 %s oct%0d", is_hi ? "hi" : "lo", o);
    if (o == 0)                    return $sformatf("R2 %s oct0", is_hi ? "hi" : "lo");
    return $sformatf("R3 %s oct%0d", is_hi ? "hi" : "lo", o);
  endfunction

  always @(negedge clk) begin
    int o;
    pair_t p;
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      o = int'(out_oct);
      if (o >= J) check("R6 octave tag in range", o, J - 1);
      else if (expq[o].size() == 0) check("R5 output without a waiting pair", o, -1);
      else begin
        p = expq[o].pop_front();
        check(tag_of(o, p.lo, 1'b0), int'(out_lo), p.lo);
        check(tag_of(o, p.hi, 1'b1), int'(out_hi), p.hi);
      end
    end
  end

  task automatic run_phase(input int cs, input int th, input int n, input int mode);
    int sent;
    bit fresh;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    coef_sel = cs[0]; thr = th[14:0];
    cs_b = cs; thr_b = th;
    for (int j = 0; j < J; j++) begin
      cnt[j] = 0;
      expq[j].delete();
      for (int i = 0; i < K; i++) hist[j][i] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);
    sent = 0;
    fresh = 1'b1;
    while (sent < n) begin
      if (fresh) begin
        case (mode)
          0: in_valid = ($urandom % 10) < 7;
          default: in_valid = 1'b1;
        endcase
        case (mode)
          2: in_data = ($urandom % 2) ? 16'sd32767 : -16'sd32768;
          3: in_data = (sent == 0) ? 16'sd16384 : 16'sd0;
          default: in_data = 16'($urandom);
        endcase
      end
      #1;
      fresh = 1'b1;
      if (in_valid && in_ready) begin
        model_in(int'(in_data));
        sent++;
      end else if (in_valid) fresh = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (60) @(negedge clk);
    for (int j = 0; j < J; j++)
      check($sformatf("R9 leftover pairs oct%0d", j), expq[j].size(), 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    run_phase(0, 0,   40,  3);  // impulse response
    run_phase(0, 0,   400, 0);  // random data, gapped valid
    run_phase(0, 250, 400, 1);  // full rate, threshold
    run_phase(1, 0,   300, 0);  // synthesis taps
    run_phase(1, 600, 300, 2);  // rails, synthesis, threshold
    run_phase(0, 100, 200, 2);  // rails, analysis
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule